// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the purely combinational arithmetic and logic stage of a small accumulator machine. Each cycle the surrounding datapath presents the current accumulator, one 8-bit second operand, the current flag byte and an operation code. The block returns the next accumulator value, the next flag byte and a write strobe that tells the caller whether the accumulator register should load the new value.

The block covers add and subtract, with and without the incoming carry; compare; bitwise AND, OR and XOR; increment and decrement; four rotates (circular and through carry, in both directions); accumulator complement; carry complement; and carry set. Each operation has its own rule for which flags it touches. A flag the operation does not own leaves the block exactly as it came in. Instruction decode, the register file, memory and decimal adjust belong to neighbouring blocks.

Top module: `acc_alu`

## Requirements
- R1: Code 0 (add) gives accOut = accIn + operand mod 256. Code 1 (add with carry) also adds the incoming CY. CY is the carry out of bit 7 and AC is the carry out of bit 3. S, Z and P follow the result.
- R2: Code 2 (subtract) gives accIn - operand mod 256 in two's complement. Code 3 (subtract with borrow) also subtracts the incoming CY. CY is 1 when a borrow leaves bit 7, and AC is 1 when a borrow passes into bit 4. S, Z and P follow the difference.
- R3: Code 4 (compare) sets every flag exactly as code 2 would, but accOut equals accIn and accWrite is 0. Equal operands give Z=1 and CY=0. accIn greater gives Z=0 and CY=0. accIn smaller gives CY=1.
- R4: Codes 5, 6 and 7 (AND, OR, XOR) write the bitwise result and update S, Z and P. All three clear CY. AND sets AC, while OR and XOR clear AC.
- R5: Code 8 (increment) and code 9 (decrement) change accIn by one and ignore operand. They update S, Z, P and AC, where AC is the bit-3 carry for increment and the bit-4 borrow for decrement. CY keeps its incoming value.
- R6: Code 10 rotates left circularly, so bit 7 goes to bit 0 and also to CY. Code 11 rotates right circularly, so bit 0 goes to bit 7 and also to CY. No other flag changes.
- R7: Code 12 rotates left through carry: bit 7 goes to CY and the old CY goes to bit 0. Code 13 rotates right through carry: bit 0 goes to CY and the old CY goes to bit 7. No other flag changes.
- R8: Code 14 inverts all eight accumulator bits and leaves the whole flag byte unchanged.
- R9: Code 15 inverts CY and code 16 sets CY to 1. For both, accOut equals accIn, accWrite is 0, and no other flag bit changes.
- R10: The flag byte layout is S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bits 5, 3 and 1 pass from flagsIn to flagsOut unchanged for every code. S is result bit 7. Z is 1 when the result is 00h. P is 1 when the result holds an even number of one bits.
- R11: accWrite is 0 for codes 4, 15, 16 and for the unassigned codes 17 to 31, and it is 1 for every other code. Whenever accWrite is 0, accOut equals accIn. Unassigned codes also return flagsIn unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| accIn | input | 8 | Current accumulator value |
| operand | input | 8 | Second operand (register, memory or immediate byte) |
| flagsIn | input | 8 | Current flag byte |
| opSel | input | 5 | Operation code |
| accOut | output | 8 | Next accumulator value |
| flagsOut | output | 8 | Next flag byte |
| accWrite | output | 1 | High when the accumulator should load accOut |

## Verification
The block holds no state, so a wrong decode or a wrong flag rule appears at the ports in the same cycle the operation code is applied. A vector table exercises every code, including the carry, borrow and nibble-boundary cases and flag bytes with the pass-through bits set. A swept set of operand pairs then compares add and subtract against plain integer arithmetic. A flag taken from the wrong source most often shows as a CY or AC mismatch on rows where the incoming flag differs from the computed one, so flag inputs are chosen to disagree with the expected outputs wherever possible.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  // flag byte bit positions (neighbouring logic decodes these)
  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_AC = 4;
  localparam int FLAG_P  = 2;
  localparam int FLAG_CY = 0;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,
    OP_ADC = 5'd1,
    OP_SUB = 5'd2,
    OP_SBB = 5'd3,
    OP_CMP = 5'd4,
    OP_AND = 5'd5,
    OP_OR  = 5'd6,
    OP_XOR = 5'd7,
    OP_INC = 5'd8,
    OP_DEC = 5'd9,
    OP_RLC = 5'd10,
    OP_RRC = 5'd11,
    OP_RAL = 5'd12,
    OP_RAR = 5'd13,
    OP_CMA = 5'd14,
    OP_CMC = 5'd15,
    OP_STC = 5'd16
  } aluOp_e;

  localparam int OP_LAST = 16;

  typedef enum logic [2:0] {
    U_PASS, U_ADD, U_AND, U_OR, U_XOR, U_ROT, U_NOT
  } unit_e;

  typedef enum logic [1:0] {
    AC_KEEP, AC_ARITH, AC_SET, AC_CLEAR
  } acMode_e;

  typedef enum logic [2:0] {
    CY_KEEP, CY_ARITH, CY_CLEAR, CY_ROT, CY_INVERT, CY_SET
  } cyMode_e;

  typedef struct packed {
    unit_e   unit;
    logic    useOne;    // second adder input is the constant one
    logic    subtract;  // invert operand, carry becomes borrow
    logic    useCarry;  // fold incoming CY into the adder
    logic    rotRight;
    logic    rotThru;   // rotate through CY instead of circular
    logic    updSzp;
    acMode_e acMode;
    cyMode_e cyMode;
    logic    writeAcc;
  } aluCtrl_t;

endpackage

// File: rtl/alu_nibble_adder.sv
module alu_nibble_adder #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              halfCarry,
  output logic              carryOut
);
  localparam int HI_W = DATA_W - NIB_W;

  logic [NIB_W:0] loSum;
  logic [HI_W:0]  hiSum;

  // split so the carry out of the low nibble is visible
  always_comb begin
    loSum = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    hiSum = {1'b0, a[DATA_W-1:NIB_W]} + {1'b0, b[DATA_W-1:NIB_W]}
          + {{HI_W{1'b0}}, loSum[NIB_W]};
  end

  assign sum       = {hiSum[HI_W-1:0], loSum[NIB_W-1:0]};
  assign halfCarry = loSum[NIB_W];
  assign carryOut  = hiSum[HI_W];
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import acc_alu_pkg::*;
#(
  parameter int OP_W = 5
) (
  input  logic [OP_W-1:0] opSel,
  output aluCtrl_t        ctrl
);
  always_comb begin
    ctrl          = '0;
    ctrl.unit     = U_PASS;
    ctrl.acMode   = AC_KEEP;
    ctrl.cyMode   = CY_KEEP;
    ctrl.writeAcc = 1'b1;
    case (opSel)
      OP_ADD, OP_ADC: begin
        ctrl.unit     = U_ADD;
        ctrl.useCarry = (opSel == OP_ADC);
        ctrl.updSzp   = 1'b1;
        ctrl.acMode   = AC_ARITH;
        ctrl.cyMode   = CY_ARITH;
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        ctrl.unit     = (opSel == OP_CMP) ? U_PASS : U_ADD;
        ctrl.subtract = 1'b1;
        ctrl.useCarry = (opSel == OP_SBB);
        ctrl.updSzp   = 1'b1;
        ctrl.acMode   = AC_ARITH;
        ctrl.cyMode   = CY_ARITH;
        ctrl.writeAcc = (opSel != OP_CMP);
      end
      OP_AND, OP_OR, OP_XOR: begin
        ctrl.unit   = (opSel == OP_AND) ? U_AND : (opSel == OP_OR) ? U_OR : U_XOR;
        ctrl.updSzp = 1'b1;
        ctrl.acMode = (opSel == OP_AND) ? AC_SET : AC_CLEAR;
        ctrl.cyMode = CY_CLEAR;
      end
      OP_INC, OP_DEC: begin
        ctrl.unit     = U_ADD;
        ctrl.useOne   = 1'b1;
        ctrl.subtract = (opSel == OP_DEC);
        ctrl.updSzp   = 1'b1;
        ctrl.acMode   = AC_ARITH;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        ctrl.unit     = U_ROT;
        ctrl.rotRight = (opSel == OP_RRC) || (opSel == OP_RAR);
        ctrl.rotThru  = (opSel == OP_RAL) || (opSel == OP_RAR);
        ctrl.cyMode   = CY_ROT;
      end
      OP_CMA: ctrl.unit = U_NOT;
      OP_CMC: begin
        ctrl.cyMode   = CY_INVERT;
        ctrl.writeAcc = 1'b0;
      end
      OP_STC: begin
        ctrl.cyMode   = CY_SET;
        ctrl.writeAcc = 1'b0;
      end
      default: ctrl.writeAcc = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] flagsIn,
  input  aluCtrl_t          ctrl,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] flagsOut
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic              cyIn;
  logic [DATA_W-1:0] bSel, bAdd, sum, rotated, result, szpSrc;
  logic              carryTerm, cin, halfCarry, carryOut;
  logic              arithCy, arithAc, rotCy;

  assign cyIn      = flagsIn[FLAG_CY];
  assign bSel      = ctrl.useOne ? ONE : operand;
  assign bAdd      = ctrl.subtract ? ~bSel : bSel;
  assign carryTerm = ctrl.useCarry & cyIn;
  assign cin       = ctrl.subtract ? ~carryTerm : carryTerm;

  alu_nibble_adder #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_adder (
    .a        (accIn),
    .b        (bAdd),
    .cin      (cin),
    .sum      (sum),
    .halfCarry(halfCarry),
    .carryOut (carryOut)
  );

  // in subtract mode a missing carry means a borrow
  assign arithCy = ctrl.subtract ? ~carryOut  : carryOut;
  assign arithAc = ctrl.subtract ? ~halfCarry : halfCarry;

  always_comb begin
    if (ctrl.rotRight) begin
      rotated = {ctrl.rotThru ? cyIn : accIn[0], accIn[DATA_W-1:1]};
      rotCy   = accIn[0];
    end else begin
      rotated = {accIn[DATA_W-2:0], ctrl.rotThru ? cyIn : accIn[DATA_W-1]};
      rotCy   = accIn[DATA_W-1];
    end
  end

  always_comb begin
    case (ctrl.unit)
      U_ADD:   result = sum;
      U_AND:   result = accIn & operand;
      U_OR:    result = accIn | operand;
      U_XOR:   result = accIn ^ operand;
      U_ROT:   result = rotated;
      U_NOT:   result = ~accIn;
      default: result = accIn;
    endcase
  end

  // compare reports flags of the difference while the accumulator holds
  assign szpSrc = (ctrl.unit == U_PASS) ? sum : result;

  always_comb begin
    flagsOut = flagsIn;
    if (ctrl.updSzp) begin
      flagsOut[FLAG_S] = szpSrc[DATA_W-1];
      flagsOut[FLAG_Z] = (szpSrc == '0);
      flagsOut[FLAG_P] = ~^szpSrc;
    end
    case (ctrl.acMode)
      AC_ARITH: flagsOut[FLAG_AC] = arithAc;
      AC_SET:   flagsOut[FLAG_AC] = 1'b1;
      AC_CLEAR: flagsOut[FLAG_AC] = 1'b0;
      default:  ;
    endcase
    case (ctrl.cyMode)
      CY_ARITH:  flagsOut[FLAG_CY] = arithCy;
      CY_CLEAR:  flagsOut[FLAG_CY] = 1'b0;
      CY_ROT:    flagsOut[FLAG_CY] = rotCy;
      CY_INVERT: flagsOut[FLAG_CY] = ~cyIn;
      CY_SET:    flagsOut[FLAG_CY] = 1'b1;
      default:   ;
    endcase
  end

  assign accOut = result;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OP_W   = 5
) (
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] flagsIn,
  input  logic [OP_W-1:0]   opSel,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] flagsOut,
  output logic              accWrite
);
  localparam int NIB_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] RSV_MASK = DATA_W'(8'h2A);

  aluCtrl_t ctrl;

  alu_ctrl #(.OP_W(OP_W)) u_ctrl (
    .opSel(opSel),
    .ctrl (ctrl)
  );

  alu_dpath #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_dpath (
    .accIn   (accIn),
    .operand (operand),
    .flagsIn (flagsIn),
    .ctrl    (ctrl),
    .accOut  (accOut),
    .flagsOut(flagsOut)
  );

  assign accWrite = ctrl.writeAcc;

  // port-level checks tying decode and datapath together
  always_comb begin
    if (opSel == OP_ADD)
      p_add_sum_r1: assert (accOut == DATA_W'(accIn + operand)) else $error("add sum");
    if (opSel == OP_SUB)
      p_sub_borrow_r2: assert (flagsOut[FLAG_CY] == (accIn < operand)) else $error("sub borrow");
    if (opSel == OP_CMP && accIn == operand)
      p_cmp_equal_r3: assert (flagsOut[FLAG_Z] && !flagsOut[FLAG_CY]) else $error("cmp equal");
    if (opSel == OP_AND || opSel == OP_OR || opSel == OP_XOR)
      p_logic_cy_r4: assert (!flagsOut[FLAG_CY]) else $error("logic carry");
    if (opSel == OP_INC || opSel == OP_DEC)
      p_step_cy_r5: assert (flagsOut[FLAG_CY] == flagsIn[FLAG_CY]) else $error("step carry");
    if (opSel == OP_RLC)
      p_rlc_wrap_r6: assert (accOut[0] == accIn[DATA_W-1] && flagsOut[FLAG_CY] == accIn[DATA_W-1])
        else $error("rlc wrap");
    if (opSel == OP_RAR)
      p_rar_thru_r7: assert (accOut[DATA_W-1] == flagsIn[FLAG_CY] && flagsOut[FLAG_CY] == accIn[0])
        else $error("rar through");
    if (opSel == OP_CMA)
      p_cma_flags_r8: assert (flagsOut == flagsIn && accOut == ~accIn) else $error("cma");
    if (opSel == OP_STC)
      p_stc_set_r9: assert (flagsOut[FLAG_CY] && accOut == accIn) else $error("stc");
    p_rsv_pass_r10: assert ((flagsOut & RSV_MASK) == (flagsIn & RSV_MASK)) else $error("reserved bits");
    if (!accWrite)
      p_hold_acc_r11: assert (accOut == accIn) else $error("hold acc");
    if (opSel > OP_W'(OP_LAST))
      p_unused_r11: assert (!accWrite && flagsOut == flagsIn) else $error("unused code");
  end
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic [7:0] accIn, operand, flagsIn;
  logic [4:0] opSel;
  logic [7:0] accOut, flagsOut;
  logic       accWrite;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  acc_alu u_acc_alu (
    .accIn(accIn), .operand(operand), .flagsIn(flagsIn), .opSel(opSel),
    .accOut(accOut), .flagsOut(flagsOut), .accWrite(accWrite)
  );

  // {req, op, acc, operand, flagsIn, expAcc, expFlags, expWrite}
  localparam int NV = 34;
  localparam logic [49:0] VEC [NV] = '{
    {4'd1,  5'd0,  8'h30, 8'h10, 8'h00, 8'h40, 8'h00, 1'b1}, // R1 add
    {4'd1,  5'd1,  8'h30, 8'h20, 8'h01, 8'h51, 8'h00, 1'b1}, // R1 add with carry
    {4'd1,  5'd0,  8'hC3, 8'hA9, 8'h00, 8'h6C, 8'h05, 1'b1}, // R1 carry out
    {4'd1,  5'd0,  8'h0F, 8'h01, 8'h00, 8'h10, 8'h10, 1'b1}, // R1 nibble carry
    {4'd10, 5'd0,  8'h80, 8'h80, 8'h00, 8'h00, 8'h45, 1'b1}, // R10 zero, parity
    {4'd10, 5'd0,  8'h01, 8'h01, 8'h2A, 8'h02, 8'h2A, 1'b1}, // R10 reserved kept
    {4'd2,  5'd2,  8'h50, 8'h30, 8'h00, 8'h20, 8'h00, 1'b1}, // R2 subtract
    {4'd2,  5'd3,  8'h50, 8'h20, 8'h01, 8'h2F, 8'h10, 1'b1}, // R2 with borrow
    {4'd2,  5'd2,  8'h12, 8'h14, 8'h00, 8'hFE, 8'h91, 1'b1}, // R2 underflow
    {4'd3,  5'd4,  8'h12, 8'h14, 8'h00, 8'h12, 8'h91, 1'b0}, // R3 smaller
    {4'd3,  5'd4,  8'h55, 8'h55, 8'h01, 8'h55, 8'h44, 1'b0}, // R3 equal
    {4'd3,  5'd4,  8'h60, 8'h20, 8'h00, 8'h60, 8'h00, 1'b0}, // R3 greater
    {4'd4,  5'd5,  8'h59, 8'h03, 8'h01, 8'h01, 8'h10, 1'b1}, // R4 and
    {4'd4,  5'd6,  8'hAB, 8'h87, 8'h11, 8'hAF, 8'h84, 1'b1}, // R4 or
    {4'd4,  5'd7,  8'hAB, 8'h12, 8'h11, 8'hB9, 8'h80, 1'b1}, // R4 xor
    {4'd4,  5'd7,  8'h5A, 8'h5A, 8'h01, 8'h00, 8'h44, 1'b1}, // R4 xor to zero
    {4'd5,  5'd8,  8'h50, 8'hFF, 8'h01, 8'h51, 8'h01, 1'b1}, // R5 inc keeps CY
    {4'd5,  5'd8,  8'hFF, 8'h00, 8'h00, 8'h00, 8'h54, 1'b1}, // R5 inc wrap
    {4'd5,  5'd9,  8'h20, 8'h00, 8'h01, 8'h1F, 8'h11, 1'b1}, // R5 dec
    {4'd5,  5'd9,  8'h00, 8'h77, 8'h00, 8'hFF, 8'h94, 1'b1}, // R5 dec wrap
    {4'd6,  5'd10, 8'h57, 8'h00, 8'hC5, 8'hAE, 8'hC4, 1'b1}, // R6 rlc
    {4'd6,  5'd10, 8'h80, 8'h00, 8'h00, 8'h01, 8'h01, 1'b1}, // R6 rlc wrap
    {4'd6,  5'd11, 8'h9A, 8'h00, 8'h01, 8'h4D, 8'h00, 1'b1}, // R6 rrc
    {4'd6,  5'd11, 8'h01, 8'h00, 8'h00, 8'h80, 8'h01, 1'b1}, // R6 rrc wrap
    {4'd7,  5'd12, 8'h80, 8'h00, 8'h00, 8'h00, 8'h01, 1'b1}, // R7 ral out
    {4'd7,  5'd12, 8'h01, 8'h00, 8'h01, 8'h03, 8'h00, 1'b1}, // R7 ral in
    {4'd7,  5'd13, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 1'b1}, // R7 rar out
    {4'd7,  5'd13, 8'h90, 8'h00, 8'h01, 8'hC8, 8'h00, 1'b1}, // R7 rar in
    {4'd8,  5'd14, 8'h88, 8'h00, 8'h95, 8'h77, 8'h95, 1'b1}, // R8 complement
    {4'd9,  5'd15, 8'h3C, 8'h00, 8'h01, 8'h3C, 8'h00, 1'b0}, // R9 cmc clear
    {4'd9,  5'd15, 8'h3C, 8'h00, 8'h2A, 8'h3C, 8'h2B, 1'b0}, // R9 cmc set
    {4'd9,  5'd16, 8'h3C, 8'h00, 8'h00, 8'h3C, 8'h01, 1'b0}, // R9 stc
    {4'd11, 5'd17, 8'h3C, 8'h00, 8'hD5, 8'h3C, 8'hD5, 1'b0}, // R11 unused code
    {4'd11, 5'd31, 8'hA5, 8'h5A, 8'hFF, 8'hA5, 8'hFF, 1'b0}  // R11 top code
  };

  task automatic check(input int req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] f);
    @(posedge clk);
    opSel = op; accIn = a; operand = b; flagsIn = f;
    @(negedge clk);
  endtask

  initial begin
    accIn = '0; operand = '0; flagsIn = '0; opSel = 5'd0;
    @(negedge clk);
    // R1 idle inputs: add of zeros gives zero with Z and P set
    check(1, "idle acc", int'(accOut), 0);
    check(10, "idle flags", int'(flagsOut), 'h44);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][45:41], VEC[i][40:33], VEC[i][32:25], VEC[i][24:17]);
      check(int'(VEC[i][49:46]), $sformatf("row %0d acc", i), int'(accOut), int'(VEC[i][16:9]));
      check(int'(VEC[i][49:46]), $sformatf("row %0d flags", i), int'(flagsOut), int'(VEC[i][8:1]));
      check(int'(VEC[i][49:46]), $sformatf("row %0d write", i), int'(accWrite), int'(VEC[i][0]));
    end

    // R5 operand has no effect on increment
    apply(5'd8, 8'h7E, 8'h00, 8'h00);
    check(5, "inc operand 00", int'({accOut, flagsOut}), 'h7F00);
    apply(5'd8, 8'h7E, 8'hA5, 8'h00);
    check(5, "inc operand A5", int'({accOut, flagsOut}), 'h7F00);

    // R1 and R2 sweep against integer arithmetic
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 29) begin
        apply(5'd0, 8'(a), 8'(b), 8'h00);
        check(1, "add sweep acc", int'(accOut), (a + b) & 'hFF);
        check(1, "add sweep cy", int'(flagsOut[0]), int'((a + b) > 255));
        apply(5'd2, 8'(a), 8'(b), 8'h01);
        check(2, "sub sweep acc", int'(accOut), (a - b) & 'hFF);
        check(2, "sub sweep cy", int'(flagsOut[0]), int'(a < b));
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule